// File: doc/BRIEF.md
# UART Transmitter with Flow Control

This block turns queued bytes into an asynchronous serial stream on a single line that idles high. Bytes come in through a write strobe. They wait in a 16-entry queue, or in a single holding slot when the queue is switched off. A sequencer then sends each byte as a frame: a low start bit, the data bits least significant first, an optional parity bit, and one, one and a half, or two stop bits. All bit timing comes from an internal divider that produces a tick at sixteen times the bit rate. Every serial bit therefore lasts sixteen ticks.

Line settings are static inputs from the surrounding register logic:

- word length
- stop selection
- parity enable, even select and stick select
- break
- queue mode
- flow-control enable

A run input acts as a soft reset for the sequencer only. While run is low the sequencer sits idle, but queued bytes and all settings are kept. With flow control on, the clear-to-send input gates the launch of each byte. The status outputs report an empty queue and a fully drained transmitter. An interrupt request is raised when the queue drains and is dropped by the next accepted write.

Top module: `uart_tx_core`

## Requirements
- R1: With divisor N > 0 each serial bit lasts exactly 16·N clock cycles. With divisor 0 no tick is made, the line stays high and queued bytes stay queued.
- R2: A frame is a start bit at 0, then `5 + word_len` data bits sent LSB first (word_len 0..3 gives 5..8 bits), then the optional parity bit, then the stop bits at 1.
- R3: With parity enabled and stick clear, the parity bit makes the count of ones over data and parity even when par_even = 1, and odd when par_even = 0. With parity disabled no parity bit is sent.
- R4: With parity enabled and stick set, the parity bit is the constant 0 when par_even = 1 and the constant 1 when par_even = 0.
- R5: With stop_sel = 0 a frame ends with one stop bit (16 ticks). With stop_sel = 1 it ends with 1.5 stop bits (24 ticks) when word_len = 0, and 2 stop bits (32 ticks) otherwise. Queued bytes are sent back to back, so start edges are one frame length apart.
- R6: While tx_run = 0 the line stays high and nothing is sent. Bytes written meanwhile stay queued and go out after tx_run returns to 1.
- R7: With flow_en = 1, a byte leaves an idle transmitter only while cts = 1. cts dropping before the middle of the final stop bit holds back the next queued byte. Dropping it after that point lets the next byte follow back to back. With flow_en = 0, cts is ignored.
- R8: empty_irq goes to 1 when the last queued byte is taken for sending, and returns to 0 one cycle after an accepted write.
- R9: hold_empty is 1 exactly when no byte is queued. tx_empty is 1 only when no byte is queued and no frame is in progress.
- R10: While brk = 1 the line is driven low, whatever the sequencer is doing.
- R11: With fifo_on = 1 the queue holds 16 bytes and with fifo_on = 0 it holds 1. A write to a full queue is dropped.
- R12: After rst_n the line is high, hold_empty and tx_empty are 1 and empty_irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| divisor | input | 16 | Clock cycles per baud tick; 0 stops the tick |
| word_len | input | 2 | Data bits minus five |
| stop_sel | input | 1 | Selects the longer stop period |
| par_en | input | 1 | Adds a parity bit |
| par_even | input | 1 | Even parity, or stick value 0 when stick is set |
| par_stick | input | 1 | Forces the parity bit to a constant |
| brk | input | 1 | Holds the line low |
| fifo_on | input | 1 | 1: 16-entry queue, 0: single slot |
| flow_en | input | 1 | Enables clear-to-send gating |
| cts | input | 1 | Clear to send, active high |
| tx_run | input | 1 | 0 holds the sequencer in reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to queue |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Queue is empty |
| tx_empty | output | 1 | Queue and shifter are both empty |
| empty_irq | output | 1 | Queue-drained interrupt request |

## Verification
The bench sends back-to-back byte pairs under every word length, each parity kind and each stop length. It checks both the decoded bits and the exact spacing of start edges. A sequencer that miscounted the half stop bit or dropped a data bit would shift the second start edge or corrupt the byte.

Clear-to-send is dropped once well before and once just after the middle of the final stop bit. A design that sampled it at the wrong point would either send the held byte or stall the one that should follow.

Divisor zero, soft reset, queue overflow in both queue modes, break, and the interrupt set and clear points are each checked at the ports.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } tx_state_e;

   // mask selecting the active data bits for a word-length code
   function automatic logic [7:0] word_mask(input logic [1:0] wl);
      logic [7:0] m;
      m = 8'h1F;
      for (int i = 5; i < 8; i++)
         if (i < 5 + int'(wl)) m[i] = 1'b1;
      return m;
   endfunction

   // parity bit value for a byte under the current line settings
   function automatic logic parity_bit(input logic [7:0] d, input logic [1:0] wl,
                                       input logic even, input logic stick);
      logic ones;
      ones = ^(d & word_mask(wl));
      if (stick) return ~even;
      return even ? ones : ~ones;
   endfunction

endpackage

// File: rtl/uart_baud_div.sv
module uart_baud_div #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (divisor == '0)     cnt <= '0;
      else if (cnt == '0)         cnt <= divisor - 1'b1;
      else                        cnt <= cnt - 1'b1;
   end

   assign tick = (divisor != '0) && (cnt == '0);

   // R1: with a stable divisor above one, ticks never come on adjacent cycles
   assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && divisor > DIV_W'(1)) |=> (!tick || divisor != $past(divisor)));

endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         single_slot,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty,
   output logic         full,
   output logic         one_left
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   logic [CW-1:0] cnt;
   logic          wr_ok, rd_ok;

   assign empty    = (cnt == '0);
   assign full     = (cnt >= (single_slot ? CW'(1) : DEPTH_C));
   assign one_left = (cnt == CW'(1));
   assign wr_ok    = wr_en && !full;
   assign rd_ok    = rd_en && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (wr_ok && !rd_ok) cnt <= cnt + 1'b1;
      else if (rd_ok && !wr_ok) cnt <= cnt - 1'b1;
   end

   generate
      if (DEPTH == 1) begin : g_slot
         logic [W-1:0] hold;
         always_ff @(posedge clk) if (wr_ok) hold <= wr_data;
         assign rd_data = hold;
      end else begin : g_ring
         localparam int AW = $clog2(DEPTH);
         logic [W-1:0]  mem [DEPTH];
         logic [AW-1:0] wp, rp;

         function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
            return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
         endfunction

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp <= '0;
               rp <= '0;
            end else begin
               if (wr_ok) wp <= nxt(wp);
               if (rd_ok) rp <= nxt(rp);
            end
         end
         always_ff @(posedge clk) if (wr_ok) mem[wp] <= wr_data;
         assign rd_data = mem[rp];
      end
   endgenerate

   // R11: a write into a full queue leaves the occupancy unchanged
   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !rd_en) |=> $stable(cnt));

   // R11: occupancy never exceeds the physical depth
   assert_depth_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= DEPTH_C);

endmodule

// File: rtl/uart_tx_serial.sv
module uart_tx_serial
   import uart_tx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       tick,
   input  logic [1:0] word_len,
   input  logic       stop_sel,
   input  logic       par_en,
   input  logic       par_even,
   input  logic       par_stick,
   input  logic       flow_en,
   input  logic       cts,
   input  logic       q_empty,
   input  logic [7:0] q_data,
   output logic       q_pop,
   output logic       line,
   output logic       busy
);
   localparam int SW = $clog2(2 * OVS);
   localparam logic [SW-1:0] BIT_LAST = SW'(OVS - 1);

   tx_state_e   st;
   logic [SW-1:0] sub, stop_last, stop_mid;
   logic [2:0]  bitn, bit_last;
   logic [7:0]  shreg;
   logic        par_q, go_q;
   logic        launch_idle, launch_next, launch;

   assign stop_last = !stop_sel       ? SW'(OVS - 1) :
                      (word_len == 0) ? SW'(OVS + OVS/2 - 1) : SW'(2*OVS - 1);
   assign stop_mid  = stop_last - SW'(OVS/2 - 1);
   assign bit_last  = {1'b0, word_len} + 3'd4;

   assign launch_idle = (st == ST_IDLE) && !q_empty && (!flow_en || cts);
   assign launch_next = (st == ST_STOP) && (sub == stop_last) && !q_empty && go_q;
   assign launch      = run && tick && (launch_idle || launch_next);
   assign q_pop       = launch;
   assign busy        = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; sub <= '0; bitn <= '0; shreg <= '0;
         par_q <= 1'b0; go_q <= 1'b0; line <= 1'b1;
      end else if (!run) begin
         st <= ST_IDLE; sub <= '0; bitn <= '0; go_q <= 1'b0; line <= 1'b1;
      end else if (launch) begin
         st    <= ST_START;
         sub   <= '0;
         shreg <= q_data;
         par_q <= parity_bit(q_data, word_len, par_even, par_stick);
         line  <= 1'b0;
      end else if (tick) begin
         case (st)
            ST_START: begin
               if (sub == BIT_LAST) begin
                  sub <= '0; bitn <= '0; st <= ST_DATA; line <= shreg[0];
               end else sub <= sub + 1'b1;
            end
            ST_DATA: begin
               if (sub == BIT_LAST) begin
                  sub <= '0;
                  if (bitn == bit_last) begin
                     st   <= par_en ? ST_PAR : ST_STOP;
                     line <= par_en ? par_q : 1'b1;
                  end else begin
                     bitn  <= bitn + 1'b1;
                     shreg <= shreg >> 1;
                     line  <= shreg[1];
                  end
               end else sub <= sub + 1'b1;
            end
            ST_PAR: begin
               if (sub == BIT_LAST) begin
                  sub <= '0; st <= ST_STOP; line <= 1'b1;
               end else sub <= sub + 1'b1;
            end
            ST_STOP: begin
               if (sub == stop_mid) go_q <= !flow_en || cts;
               if (sub == stop_last) begin
                  sub <= '0; st <= ST_IDLE; line <= 1'b1;
               end else sub <= sub + 1'b1;
            end
            default: begin
               sub <= '0; line <= 1'b1;
            end
         endcase
      end
   end

   // R6: a low run input leaves the sequencer idle with the line high
   assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (st == ST_IDLE && line));

   // R1: without a tick the sequencer and the line hold still
   assert_tick_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> ($stable(st) && $stable(line)));

   // R11: a byte is only taken from a queue that holds one
   assert_pop_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      q_pop |-> !q_empty);

   // R7: an idle launch under flow control needs clear-to-send
   assert_flow_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_pop && st == ST_IDLE && flow_en) |-> cts);

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
   parameter int DEPTH = 16,
   parameter int DIV_W = 16,
   parameter int OVS   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   input  logic [1:0]       word_len,
   input  logic             stop_sel,
   input  logic             par_en,
   input  logic             par_even,
   input  logic             par_stick,
   input  logic             brk,
   input  logic             fifo_on,
   input  logic             flow_en,
   input  logic             cts,
   input  logic             tx_run,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   output logic             txd,
   output logic             hold_empty,
   output logic             tx_empty,
   output logic             empty_irq
);
   generate
      if (DEPTH < 1)               begin : g_bad_depth $error("DEPTH must be at least 1"); end
      if (DIV_W < 2)               begin : g_bad_div   $error("DIV_W must be at least 2"); end
      if (OVS < 4 || OVS % 2 != 0) begin : g_bad_ovs   $error("OVS must be even and >= 4"); end
   endgenerate

   logic       tick, q_empty, q_full, q_last, q_pop, line, busy, irq_q;
   logic [7:0] q_data;

   uart_baud_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick));

   uart_tx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
      .clk(clk), .rst_n(rst_n), .single_slot(!fifo_on),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(q_pop), .rd_data(q_data),
      .empty(q_empty), .full(q_full), .one_left(q_last));

   uart_tx_serial #(.OVS(OVS)) u_ser (
      .clk(clk), .rst_n(rst_n), .run(tx_run), .tick(tick),
      .word_len(word_len), .stop_sel(stop_sel), .par_en(par_en),
      .par_even(par_even), .par_stick(par_stick), .flow_en(flow_en), .cts(cts),
      .q_empty(q_empty), .q_data(q_data), .q_pop(q_pop), .line(line), .busy(busy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  irq_q <= 1'b0;
      else if (wr_en && !q_full)   irq_q <= 1'b0;
      else if (q_pop && q_last)    irq_q <= 1'b1;
   end

   assign txd        = brk ? 1'b0 : line;
   assign hold_empty = q_empty;
   assign tx_empty   = q_empty && !busy;
   assign empty_irq  = irq_q;

   // R8: an accepted write clears the request on the next cycle
   assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !q_full) |=> !empty_irq);

   // R8: taking the last queued byte raises the request
   assert_irq_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (q_pop && q_last && !wr_en) |=> empty_irq);

endmodule

// File: tb/tb_uart_tx_core.sv
`timescale 1ns/1ps
module tb_uart_tx_core;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [15:0] divisor = 16'd1;
   logic [1:0] word_len = 2'd3;
   logic stop_sel = 0, par_en = 0, par_even = 0, par_stick = 0, brk = 0;
   logic fifo_on = 1, flow_en = 0, cts = 1, tx_run = 1, wr_en = 0;
   logic [7:0] wr_data = 8'h00;
   logic txd, hold_empty, tx_empty, empty_irq;

   uart_tx_core dut (.*);

   always #2.5 clk = ~clk;

   typedef struct { logic [7:0] d; int par; int gap; } exp_t;
   exp_t exp_q[$];
   int n_chk = 0, n_fail = 0, cyc = 0;
   bit mon_en = 1, done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   function automatic int nbits(); return 5 + int'(word_len); endfunction

   function automatic int stop_ticks();
      if (!stop_sel) return 16;
      return (word_len == 2'd0) ? 24 : 32;
   endfunction

   function automatic int frame_cycles();
      return (16 * (1 + nbits() + int'(par_en)) + stop_ticks()) * int'(divisor);
   endfunction

   function automatic int exp_par(input logic [7:0] d);
      logic ones;
      if (!par_en) return -1;
      if (par_stick) return par_even ? 0 : 1;           // R4
      ones = 1'b0;
      for (int i = 0; i < nbits(); i++) ones ^= d[i];
      return par_even ? int'(ones) : int'(!ones);       // R3
   endfunction

   task automatic put_byte(input logic [7:0] d, input bit keep, input int gap);
      exp_t e;
      if (keep) begin
         e.d = d; e.par = exp_par(d); e.gap = gap;
         exp_q.push_back(e);
      end
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic wait_drain();
      do @(negedge clk); while (!(tx_empty && hold_empty));
      repeat (20) @(negedge clk);
   endtask

   task automatic wait_start();
      do @(negedge clk); while (txd !== 1'b0);
   endtask

   // scoreboard monitor: decodes frames off the line and compares
   initial begin
      logic prev = 1'b1;
      int last_t0 = 0;
      forever begin
         @(negedge clk);
         if (mon_en && prev === 1'b1 && txd === 1'b0 && divisor != 0) begin
            int t0, bt, p;
            logic [7:0] d;
            exp_t e;
            t0 = cyc; bt = 16 * int'(divisor); d = '0; p = -1;
            repeat (bt / 2) @(negedge clk);
            chk(txd === 1'b0, "R2", "start bit", int'(txd), 0);
            for (int i = 0; i < nbits(); i++) begin
               repeat (bt) @(negedge clk);
               d[i] = txd;
            end
            if (par_en) begin
               repeat (bt) @(negedge clk);
               p = int'(txd);
            end
            repeat (bt) @(negedge clk);
            chk(txd === 1'b1, "R5", "stop bit", int'(txd), 1);
            if (exp_q.size() == 0) begin
               chk(0, "R2", "unexpected frame", int'(d), -1);
            end else begin
               e = exp_q.pop_front();
               chk(d == (e.d & 8'((1 << nbits()) - 1)), "R2", "data",
                   int'(d), int'(e.d & 8'((1 << nbits()) - 1)));
               chk(p == e.par, par_stick ? "R4" : "R3", "parity", p, e.par);
               if (e.gap > 0)
                  chk(t0 - last_t0 == e.gap, "R5", "start spacing", t0 - last_t0, e.gap);
            end
            last_t0 = t0;
         end
         prev = txd;
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "R1", "watchdog expired", cyc, 150000);
      finish_run();
   end

   // two back-to-back bytes under the current line settings
   task automatic pair(input logic [7:0] a, input logic [7:0] b);
      int hi;
      tx_run = 1'b0;
      put_byte(a, 1, -1);
      put_byte(b, 1, frame_cycles());
      hi = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) hi++;
      end
      chk(hi == 0 && !hold_empty, "R6", "idle while run low", hi, 0);
      tx_run = 1'b1;
      wait_drain();
      chk(exp_q.size() == 0, "R2", "frames pending", exp_q.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(txd === 1'b1, "R12", "txd", int'(txd), 1);
      chk(hold_empty === 1'b1, "R12", "hold_empty", int'(hold_empty), 1);
      chk(tx_empty === 1'b1, "R12", "tx_empty", int'(tx_empty), 1);
      chk(empty_irq === 1'b0, "R12", "empty_irq", int'(empty_irq), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R2 R5: 8 data, no parity, one stop
      pair(8'hA5, 8'h3C);
      // R1 R3 R5: divisor 2, 5 data, odd parity, 1.5 stop
      divisor = 16'd2; word_len = 2'd0; par_en = 1; par_even = 0; stop_sel = 1;
      pair(8'h15, 8'hEA);
      // R3 R5: 6 data, even parity, two stop
      divisor = 16'd1; word_len = 2'd1; par_even = 1;
      pair(8'h2D, 8'h07);
      // R4: stick parity forced to 0, 7 data
      word_len = 2'd2; par_stick = 1; par_even = 1;
      pair(8'h7F, 8'h01);
      // R4: stick parity forced to 1, 8 data, one stop
      word_len = 2'd3; par_even = 0; stop_sel = 0;
      pair(8'h00, 8'hC3);
      par_en = 0; par_stick = 0;

      // R1: divisor zero stops everything
      begin
         int moved = 0;
         divisor = 16'd0;
         put_byte(8'h5A, 1, -1);
         for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) moved++;
         end
         chk(moved == 0 && !hold_empty, "R1", "divisor 0 held byte", moved, 0);
         divisor = 16'd1;
         wait_drain();
         chk(exp_q.size() == 0, "R1", "sent after divisor set", exp_q.size(), 0);
      end

      // R8 R9: status during and after a single frame
      put_byte(8'h96, 1, -1);
      wait_start();
      chk(hold_empty === 1'b1, "R9", "hold_empty while shifting", int'(hold_empty), 1);
      chk(tx_empty === 1'b0, "R9", "tx_empty while shifting", int'(tx_empty), 0);
      chk(empty_irq === 1'b1, "R8", "irq after last pop", int'(empty_irq), 1);
      wait_drain();
      chk(tx_empty === 1'b1, "R9", "tx_empty after frame", int'(tx_empty), 1);
      tx_run = 1'b0;
      put_byte(8'h44, 1, -1);
      chk(empty_irq === 1'b0, "R8", "irq cleared by write", int'(empty_irq), 0);
      chk(hold_empty === 1'b0, "R9", "hold_empty with byte", int'(hold_empty), 0);
      tx_run = 1'b1;
      wait_drain();

      // R11: sixteen kept, extra writes dropped
      tx_run = 1'b0;
      for (int i = 0; i < 18; i++) put_byte(8'(8'h10 + i), i < 16, -1);
      tx_run = 1'b1;
      wait_drain();
      chk(exp_q.size() == 0, "R11", "deep queue frames", exp_q.size(), 0);
      // R11: single slot when the queue is off
      fifo_on = 1'b0; tx_run = 1'b0;
      put_byte(8'h81, 1, -1);
      put_byte(8'h82, 0, -1);
      tx_run = 1'b1;
      wait_drain();
      chk(exp_q.size() == 0, "R11", "single slot frames", exp_q.size(), 0);
      fifo_on = 1'b1;

      // R7: cts dropped early holds the next byte
      flow_en = 1'b1; cts = 1'b1; tx_run = 1'b0;
      put_byte(8'h11, 1, -1);
      put_byte(8'h22, 1, -1);
      tx_run = 1'b1;
      wait_start();
      repeat (100) @(negedge clk);
      cts = 1'b0;
      repeat (400) @(negedge clk);
      chk(hold_empty === 1'b0 && txd === 1'b1, "R7", "byte held by cts",
          int'(hold_empty), 0);
      chk(exp_q.size() == 1, "R7", "frames sent before cts", exp_q.size(), 1);
      cts = 1'b1;
      wait_drain();
      chk(exp_q.size() == 0, "R7", "held byte released", exp_q.size(), 0);
      // R7: cts dropped after the middle of the final stop bit
      tx_run = 1'b0;
      put_byte(8'h33, 1, -1);
      put_byte(8'h44, 1, frame_cycles());
      tx_run = 1'b1;
      wait_start();
      repeat (156) @(negedge clk);
      cts = 1'b0;
      wait_drain();
      chk(exp_q.size() == 0, "R7", "late drop still sends", exp_q.size(), 0);
      // R7: flow control off ignores cts
      flow_en = 1'b0;
      put_byte(8'h55, 1, -1);
      wait_drain();
      chk(exp_q.size() == 0, "R7", "cts ignored", exp_q.size(), 0);
      cts = 1'b1;

      // R10: break holds the line low
      mon_en = 1'b0;
      @(negedge clk); brk = 1'b1;
      @(negedge clk);
      chk(txd === 1'b0, "R10", "break low", int'(txd), 0);
      repeat (40) @(negedge clk);
      chk(txd === 1'b0, "R10", "break held", int'(txd), 0);
      brk = 1'b0;
      @(negedge clk);
      chk(txd === 1'b1, "R10", "break released", int'(txd), 1);
      repeat (20) @(negedge clk);
      mon_en = 1'b1;

      finish_run();
   end
endmodule